// File: doc/BRIEF.md
# T1 Receive Frame Timing Generator

This block produces the receive-side timing strobes for a 1.544 Mb/s T1 stream once an upstream aligner has found the frame position. One chain of counters (bit in slot, slot in frame, frame in multiframe) advances on every line clock. The frame sync, channel clock, multiframe sync, signaling strobes and link clock are all decoded from that chain. A one-cycle alignment pulse forces the chain onto the framing bit of the first frame of a multiframe.

A mode input selects 12-frame superframe (SF) or 24-frame extended superframe (ESF) operation. The mode changes the multiframe length, the signaling-select pattern and the parity of the frames that carry the link bit. The framing bit of each link frame is captured from the serial data. It is presented on a held output one clock before the next frame that is due to deliver it, and it stays there until the next update.

Top module: `t1_rx_timing`

## Requirements
- R1: While rst_ni is low and on the first cycle after it is released, the block is at the framing bit of frame 1. fsync_o and msync_o are 1, ldata_o is 0, and the frame counter is cleared.
- R2: A frame is 193 clocks long: one framing bit, then 24 slots of 8 bits. fsync_o is 1 only during the framing bit.
- R3: chclk_o is 1 during bits 0 to 3 of each 8-bit slot. It is 0 during bits 4 to 7 and during the framing bit.
- R4: A 1 on frame_start_i makes the next cycle the framing bit of frame 1.
- R5: The multiframe is 12 frames long when esf_mode_i is 0 and 24 frames long when it is 1. msync_o is 1 during the first half of the multiframe and 0 during the second half, so it rises at the framing bit of frame 1.
- R6: sigfr_o is 1 for the whole of frames 6, 12, 18 and 24, the frame numbers that are multiples of 6. It is 0 in all other frames and in every cycle where resync_i is 1.
- R7: In SF mode, sigsel_o is 1 in frames 6, 7, 8, 12, 1 and 2. In ESF mode it is 1 in frames 6 to 11 and 18 to 23. It only changes at a framing bit.
- R8: lclk_o is 1 during odd-numbered frames in ESF mode and during even-numbered frames in SF mode. It is 0 in the other frames.
- R9: The value of data_i during the framing bit of a frame in which lclk_o is 1 is captured. It appears on ldata_o in the last bit cycle of the following frame (bit 7 of slot 24). It is held until the next update.
- R10: If the mode changes while the frame counter is beyond the new multiframe length, the counter returns to frame 1 at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1.544 MHz line clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Alignment pulse; the next cycle is the framing bit of frame 1 |
| resync_i | input | 1 | Resync in progress; forces sigfr_o low |
| esf_mode_i | input | 1 | 0 = SF (12 frames), 1 = ESF (24 frames) |
| data_i | input | 1 | Received serial data |
| fsync_o | output | 1 | Framing-bit strobe |
| chclk_o | output | 1 | Slot clock, high in the first half of each slot |
| msync_o | output | 1 | Multiframe sync, 50% duty cycle |
| sigfr_o | output | 1 | Signaling-frame flag |
| sigsel_o | output | 1 | Signaling-select clock |
| lclk_o | output | 1 | Link-data clock, 2-frame period |
| ldata_o | output | 1 | Held link bit |

## Verification
The bench builds the block with its default parameters: 8-bit slots, 24 slots, 12- and 24-frame multiframes and signaling every 6 frames. Under these values both multiframe wrap points, frame 24 as a signaling frame, and a switch from ESF to SF while the counter is past frame 12 all occur within a few tens of thousands of cycles. A behavioural reference model tracks the bit position and frame number as plain integers. It checks every output on every clock through alignment pulses, a long resync window, mode changes and a reset in mid-run.

// File: rtl/t1_rx_pkg.sv
package t1_rx_pkg;
  localparam int T1_SLOT_BITS   = 8;
  localparam int T1_SLOTS       = 24;
  localparam int T1_SF_FRAMES   = 12;
  localparam int T1_ESF_FRAMES  = 24;
  localparam int T1_SIG_SPACING = 6;
endpackage

// File: rtl/t1_rx_wrap_cnt.sv
module t1_rx_wrap_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q >= last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q >= last_i) ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/t1_rx_frame_pos.sv
module t1_rx_frame_pos #(
  parameter int SLOT_BITS  = 8,
  parameter int SLOTS      = 24,
  parameter int SF_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  localparam int BW = $clog2(SLOT_BITS),
  localparam int SW = $clog2(SLOTS),
  localparam int FW = $clog2(ESF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          esf_i,
  output logic          fbit_o,
  output logic [BW-1:0] bit_o,
  output logic [SW-1:0] slot_o,
  output logic [FW-1:0] frm_o
);
  logic          fbit_q;
  logic          bit_wrap, slot_wrap, frm_wrap;
  logic [FW-1:0] frm_last;

  assign frm_last = esf_i ? FW'(ESF_FRAMES - 1) : FW'(SF_FRAMES - 1);

  t1_rx_wrap_cnt #(.W(BW)) u_bit (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(!fbit_q),
    .last_i(BW'(SLOT_BITS - 1)), .cnt_o(bit_o), .wrap_o(bit_wrap)
  );

  t1_rx_wrap_cnt #(.W(SW)) u_slot (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(bit_wrap),
    .last_i(SW'(SLOTS - 1)), .cnt_o(slot_o), .wrap_o(slot_wrap)
  );

  t1_rx_wrap_cnt #(.W(FW)) u_frm (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(slot_wrap),
    .last_i(frm_last), .cnt_o(frm_o), .wrap_o(frm_wrap)
  );

  // framing bit follows the last slot of every frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fbit_q <= 1'b1;
    else if (start_i) fbit_q <= 1'b1;
    else              fbit_q <= slot_wrap;
  end

  assign fbit_o = fbit_q;

  p_fbit_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fbit_q && !start_i) |=> !fbit_q);

  p_start_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (fbit_q && frm_o == '0 && slot_o == '0 && bit_o == '0));

  p_frame_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_wrap && !start_i) |=> (frm_o <= $past(frm_last)));

  p_frame_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_wrap && !start_i) |=> (frm_o == '0 && fbit_q));
endmodule

// File: rtl/t1_rx_strobes.sv
module t1_rx_strobes #(
  parameter int SLOT_BITS   = 8,
  parameter int SF_FRAMES   = 12,
  parameter int ESF_FRAMES  = 24,
  parameter int SIG_SPACING = 6,
  localparam int BW = $clog2(SLOT_BITS),
  localparam int FW = $clog2(ESF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fbit_i,
  input  logic [BW-1:0] bit_i,
  input  logic [FW-1:0] frm_i,
  input  logic          esf_i,
  input  logic          resync_i,
  output logic          fsync_o,
  output logic          chclk_o,
  output logic          msync_o,
  output logic          sigfr_o,
  output logic          sigsel_o,
  output logic          lclk_o
);
  localparam int HALF_SF  = SF_FRAMES / 2;
  localparam int HALF_ESF = ESF_FRAMES / 2;
  localparam int HALF_SIG = SIG_SPACING / 2;

  int   fnum;
  logic sig_frame;

  always_comb begin
    fnum      = int'(frm_i) + 1;
    sig_frame = (fnum % SIG_SPACING) == 0;
    fsync_o   = fbit_i;
    chclk_o   = !fbit_i && (int'(bit_i) < SLOT_BITS / 2);
    msync_o   = int'(frm_i) < (esf_i ? HALF_ESF : HALF_SF);
    sigfr_o   = sig_frame && !resync_i;
    // ESF: high from A to B and from C to D; SF: half of each signaling span
    if (esf_i) sigsel_o = ((fnum + SIG_SPACING) % (2 * SIG_SPACING)) < SIG_SPACING;
    else       sigsel_o = (fnum % SIG_SPACING) < HALF_SIG;
    lclk_o    = esf_i ? !frm_i[0] : frm_i[0];
  end

  p_msync_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msync_o) |-> (fbit_i && frm_i == '0));

  p_sigsel_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sigsel_o) && $stable(esf_i)) |-> fbit_i);

  p_lclk_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lclk_o) && $stable(esf_i)) |-> fbit_i);
endmodule

// File: rtl/t1_rx_link.sv
module t1_rx_link #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 24,
  localparam int BW = $clog2(SLOT_BITS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fbit_i,
  input  logic [BW-1:0] bit_i,
  input  logic [SW-1:0] slot_i,
  input  logic          src_i,
  input  logic          data_i,
  output logic          ldata_o
);
  logic cap_q, ldata_q, upd;

  // load one bit early so the output is valid in the last bit of the frame
  assign upd = !src_i && !fbit_i && slot_i == SW'(SLOTS - 1) && bit_i == BW'(SLOT_BITS - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= 1'b0;
      ldata_q <= 1'b0;
    end else begin
      if (fbit_i && src_i) cap_q   <= data_i;
      if (upd)             ldata_q <= cap_q;
    end
  end

  assign ldata_o = ldata_q;

  p_ldata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(ldata_q));

  p_ldata_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (ldata_q == $past(cap_q)));
endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing
  import t1_rx_pkg::*;
#(
  parameter int SLOT_BITS   = T1_SLOT_BITS,
  parameter int SLOTS       = T1_SLOTS,
  parameter int SF_FRAMES   = T1_SF_FRAMES,
  parameter int ESF_FRAMES  = T1_ESF_FRAMES,
  parameter int SIG_SPACING = T1_SIG_SPACING
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic resync_i,
  input  logic esf_mode_i,
  input  logic data_i,
  output logic fsync_o,
  output logic chclk_o,
  output logic msync_o,
  output logic sigfr_o,
  output logic sigsel_o,
  output logic lclk_o,
  output logic ldata_o
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(SLOTS);
  localparam int FW = $clog2(ESF_FRAMES);

  logic          fbit;
  logic [BW-1:0] bit_pos;
  logic [SW-1:0] slot_pos;
  logic [FW-1:0] frm_pos;
  logic          lclk;

  t1_rx_frame_pos #(
    .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES)
  ) u_pos (
    .clk_i, .rst_ni, .start_i(frame_start_i), .esf_i(esf_mode_i),
    .fbit_o(fbit), .bit_o(bit_pos), .slot_o(slot_pos), .frm_o(frm_pos)
  );

  t1_rx_strobes #(
    .SLOT_BITS(SLOT_BITS), .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES),
    .SIG_SPACING(SIG_SPACING)
  ) u_strb (
    .clk_i, .rst_ni, .fbit_i(fbit), .bit_i(bit_pos), .frm_i(frm_pos),
    .esf_i(esf_mode_i), .resync_i, .fsync_o, .chclk_o, .msync_o,
    .sigfr_o, .sigsel_o, .lclk_o(lclk)
  );

  t1_rx_link #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_link (
    .clk_i, .rst_ni, .fbit_i(fbit), .bit_i(bit_pos), .slot_i(slot_pos),
    .src_i(lclk), .data_i, .ldata_o
  );

  assign lclk_o = lclk;

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (fsync_o && msync_o) || rst_ni);
endmodule

// File: tb/sim_t1_rx_timing.sv
module sim_t1_rx_timing;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_start = 1'b0, resync = 1'b0, esf = 1'b0, data = 1'b0;
  logic fsync, chclk, msync, sigfr, sigsel, lclk, ldata;

  int total = 0, bad = 0;
  int rp = 0, rk = 0;
  logic rcap = 1'b0, rldata = 1'b0;

  always #4 clk = ~clk;

  t1_rx_timing u0 (
    .clk_i(clk), .rst_ni, .frame_start_i(frame_start), .resync_i(resync),
    .esf_mode_i(esf), .data_i(data), .fsync_o(fsync), .chclk_o(chclk),
    .msync_o(msync), .sigfr_o(sigfr), .sigsel_o(sigsel), .lclk_o(lclk), .ldata_o(ldata)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t pos=%0d frame=%0d act=%b exp=%b", req, $time, rp, rk + 1, act, exp);
    end
  endtask

  function automatic logic src_frame();
    return esf ? (rk % 2 == 0) : (rk % 2 == 1);
  endfunction

  task automatic compare_all();
    chk("R2 fsync", fsync, rp == 0);
    chk("R3 chclk", chclk, rp != 0 && ((rp - 1) % 8) < 4);
    chk("R5 msync", msync, rk < (esf ? 12 : 6));
    chk("R6 sigfr", sigfr, ((rk + 1) % 6 == 0) && !resync);
    chk("R7 sigsel", sigsel, esf ? (((rk + 7) % 12) < 6) : (((rk + 1) % 6) < 3));
    chk("R8 lclk", lclk, src_frame());
    chk("R9 ldata", ldata, rldata);
  endtask

  task automatic model_step();
    logic src;
    src = src_frame();
    if (rp == 0 && src) rcap = data;
    else if (rp == 191 && !src) rldata = rcap;
    if (frame_start) begin
      rp = 0; rk = 0;
    end else if (rp == 192) begin
      rp = 0;
      rk = (rk >= (esf ? 23 : 11)) ? 0 : rk + 1; // R10 wrap beyond new length
    end else rp++;
  endtask

  task automatic cyc(input logic st);
    @(negedge clk);
    compare_all();
    frame_start = st;
    data = 1'($urandom);
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    frame_start = 1'b0;
    rp = 0; rk = 0; rcap = 1'b0; rldata = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset fsync", fsync, 1'b1);
    chk("R1 reset msync", msync, 1'b1);
    chk("R1 reset ldata", ldata, 1'b0);
    rst_ni = 1'b1;
    #1;
    chk("R1 post-release fsync", fsync, 1'b1);
    chk("R1 post-release ldata", ldata, 1'b0);
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic align();
    cyc(1'b1);
    @(negedge clk);
    chk("R4 align fsync", fsync, 1'b1);
    chk("R4 align msync", msync, 1'b1);
    frame_start = 1'b0;
    @(posedge clk);
    #1 model_step();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    run(2 * 12 * 193 + 50);           // SF free run
    resync = 1'b1;                    // R6 sigfr forced low
    run(3000);
    resync = 1'b0;
    run(77);
    align();                          // R4 mid-frame alignment
    run(12 * 193);
    @(negedge clk); esf = 1'b1;
    @(posedge clk); #1;
    align();
    run(2 * 24 * 193);
    while (!(rk == 15 && rp == 50)) cyc(1'b0);
    @(negedge clk);
    compare_all();
    esf = 1'b0;                       // R10 switch past SF length
    data = 1'($urandom);
    @(posedge clk); #1 model_step();
    run(2 * 12 * 193);
    do_reset();
    run(600);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule